// File: doc/BRIEF.md
# Keyboard command responder

This block is the keyboard end of a serial keyboard link. The host sends command bytes through a single-cycle strobe. The block answers by pushing reply bytes into a receive queue, which the host drains through a pop port. The pop port exposes the head byte, the fill count, and empty and full flags. On the other side, raw scan events arrive one byte per strobe. Each event goes through a lock-key filter and an optional extended-prefix stage. It is then translated into a key code, with the raw release bit carried across, and pushed into the same queue.

Multi-byte replies leave a sequencer state machine one byte per clock. The states are:

- `ST_IDLE`: accepts commands.
- `ST_ID_HEAD`, `ST_ID_TYPE`, `ST_ID_TAIL`: the identity reply.
- `ST_LAY_HEAD`, `ST_LAY_VAL`: the layout reply.

The transitions are:

- idle to `ST_ID_HEAD` on a reset command.
- idle to `ST_LAY_HEAD` on either layout query.
- each reply state to the next one, unconditionally.
- the last reply state back to idle.

While the sequencer is away from idle it owns the queue's write side, and `busy` is high.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the queue is empty (`q_count`=0, `q_empty`=1, `q_full`=0), `pop_data` is 0x00 and `busy` is 0.
- R2: An accepted command 0x01 empties the queue in its own cycle. It then raises `busy` and pushes 0xFF, 0x04 and 0x7F on the following three clocks, in that order, after which `busy` falls.
- R3: An accepted command 0x0E arms a skip flag. The next accepted command byte, whatever its value, is ignored: no clear, no push, no state change. The flag is then disarmed.
- R4: An accepted command 0x07 or 0x0F empties the queue, then pushes 0xFE and 0x00 on the next two clocks.
- R5: Any other command value is ignored and leaves the queue contents and count unchanged.
- R6: While `busy` is high, command bytes and scan events are discarded entirely. A scan event arriving in the same cycle as an accepted 0x01, 0x07 or 0x0F is also discarded.
- R7: A scan byte b that is not dropped produces the code T[b & 0x7F] | (b & 0x80). In the base table T, 0x01->0x1D, 0x10->0x36, 0x1C->0x59, 0x3A->0x77 and 0x45->0x62, and every other index maps to 0x00.
- R8: Scan byte 0xE0 pushes nothing and arms an extended flag. The next non-dropped byte is translated through the extended table (0x1C->0x5A, 0x35->0x6D, 0x47->0x44, all others 0x00), and the flag then clears.
- R9: Each lock key keeps a two-bit state that starts at 0. The caps key uses press 0x3A and release 0xBA; the num key uses 0x45 and 0xC5. A press flips bit 0 and is dropped when the new state is 2. A release flips bit 1 and is dropped when the new state is 3. A dropped event leaves the extended flag untouched.
- R10: The queue holds DEPTH (256) bytes. A push while `q_count` equals DEPTH is discarded, and `q_full` is high exactly then.
- R11: The queue is first-in first-out. `pop_data` shows the head byte without popping. A pop removes the head. While the queue is empty, `pop_data` reads 0x00 and a pop changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| scan_valid | input | 1 | Raw scan event strobe |
| scan_byte | input | 8 | Raw scan byte, bit 7 = release |
| pop | input | 1 | Remove the head byte of the queue |
| pop_data | output | 8 | Head byte of the queue, 0x00 when empty |
| q_count | output | $clog2(DEPTH+1) | Number of bytes queued |
| q_empty | output | 1 | Queue holds no byte |
| q_full | output | 1 | Queue holds DEPTH bytes |
| busy | output | 1 | Reply sequencer is emitting a multi-byte answer |

## Verification
The hardest situation to reach from the ports is a collision. One form is a scan event or a second command landing while a reply is being sequenced. The other is a scan event landing in the very cycle a clearing command is accepted. Directed steps drive a scan strobe and a layout query during the identity reply, and a scan strobe together with a layout query in one cycle. Draining the queue then shows that only the reply bytes survived. The lock filter's drop pattern and a full queue are also reached on purpose: by alternating press and release bytes, and by streaming DEPTH scan events followed by one more. Random scan traffic mixed with pops then compares against a bench model.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID_HEAD,
        ST_ID_TYPE,
        ST_ID_TAIL,
        ST_LAY_HEAD,
        ST_LAY_VAL
    } seq_state_e;

    localparam logic [7:0] CMD_RESET    = 8'h01;
    localparam logic [7:0] CMD_LED      = 8'h0E;
    localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
    localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

    localparam logic [7:0] RSP_ID_HEAD  = 8'hFF;
    localparam logic [7:0] RSP_ID_TYPE  = 8'h04;
    localparam logic [7:0] RSP_ID_TAIL  = 8'h7F;
    localparam logic [7:0] RSP_LAY_HEAD = 8'hFE;
    localparam logic [7:0] RSP_LAY_VAL  = 8'h00;

    localparam logic [7:0] SCAN_EXT   = 8'hE0;
    localparam logic [7:0] CAPS_PRESS = 8'h3A;
    localparam logic [7:0] CAPS_REL   = 8'hBA;
    localparam logic [7:0] NUM_PRESS  = 8'h45;
    localparam logic [7:0] NUM_REL    = 8'hC5;

    function automatic logic [7:0] map_base(input logic [6:0] k);
        logic [7:0] r;
        case (k)
            7'h01:   r = 8'h1D;
            7'h10:   r = 8'h36;
            7'h1C:   r = 8'h59;
            7'h3A:   r = 8'h77;
            7'h45:   r = 8'h62;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] map_ext(input logic [6:0] k);
        logic [7:0] r;
        case (k)
            7'h1C:   r = 8'h5A;
            7'h35:   r = 8'h6D;
            7'h47:   r = 8'h44;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign do_push  = push && !full && !clear;
    assign do_pop   = pop && !empty && !clear;
    assign pop_data = empty ? '0 : mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/kbd_scan_xlate.sv
module kbd_scan_xlate
    import kbd_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_take,
    input  logic [7:0] scan_byte,
    output logic       code_valid,
    output logic [7:0] code
);
    localparam int NKEYS = 2;

    logic [NKEYS-1:0] key_drop;
    logic             ext_q;
    logic             is_prefix;
    logic             any_drop;

    for (genvar g = 0; g < NKEYS; g++) begin : g_lock
        localparam logic [7:0] PRESS = (g == 0) ? CAPS_PRESS : NUM_PRESS;
        localparam logic [7:0] REL   = (g == 0) ? CAPS_REL   : NUM_REL;
        logic [1:0] st_q, st_d;
        logic       drop;

        always_comb begin
            st_d = st_q;
            drop = 1'b0;
            if (scan_byte == PRESS) begin
                st_d = st_q ^ 2'b01;
                drop = (st_d == 2'b10);
            end else if (scan_byte == REL) begin
                st_d = st_q ^ 2'b10;
                drop = (st_d == 2'b11);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)         st_q <= 2'b00;
            else if (scan_take) st_q <= st_d;
        end

        assign key_drop[g] = drop;
    end

    assign is_prefix  = (scan_byte == SCAN_EXT);
    assign any_drop   = |key_drop;
    assign code_valid = scan_take && !is_prefix && !any_drop;

    always_comb begin
        code = ext_q ? map_ext(scan_byte[6:0]) : map_base(scan_byte[6:0]);
        code = code | {scan_byte[7], 7'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else if (scan_take) begin
            if (is_prefix)      ext_q <= 1'b1;
            else if (!any_drop) ext_q <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
    import kbd_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       busy,
    output logic       clear_q,
    output logic       rsp_push,
    output logic [7:0] rsp_data,
    output logic       led_skip
);
    seq_state_e st_q, st_d;
    logic       led_set, led_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       led_skip <= 1'b0;
        else if (led_clr) led_skip <= 1'b0;
        else if (led_set) led_skip <= 1'b1;
    end

    always_comb begin
        st_d     = st_q;
        clear_q  = 1'b0;
        rsp_push = 1'b0;
        rsp_data = '0;
        led_set  = 1'b0;
        led_clr  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (led_skip) begin
                        led_clr = 1'b1;
                    end else begin
                        case (cmd_byte)
                            CMD_RESET: begin
                                clear_q = 1'b1;
                                st_d    = ST_ID_HEAD;
                            end
                            CMD_LED: led_set = 1'b1;
                            CMD_LAYOUT_A, CMD_LAYOUT_B: begin
                                clear_q = 1'b1;
                                st_d    = ST_LAY_HEAD;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            ST_ID_HEAD: begin
                rsp_push = 1'b1;
                rsp_data = RSP_ID_HEAD;
                st_d     = ST_ID_TYPE;
            end
            ST_ID_TYPE: begin
                rsp_push = 1'b1;
                rsp_data = RSP_ID_TYPE;
                st_d     = ST_ID_TAIL;
            end
            ST_ID_TAIL: begin
                rsp_push = 1'b1;
                rsp_data = RSP_ID_TAIL;
                st_d     = ST_IDLE;
            end
            ST_LAY_HEAD: begin
                rsp_push = 1'b1;
                rsp_data = RSP_LAY_HEAD;
                st_d     = ST_LAY_VAL;
            end
            ST_LAY_VAL: begin
                rsp_push = 1'b1;
                rsp_data = RSP_LAY_VAL;
                st_d     = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [7:0]                 cmd_byte,
    input  logic                       scan_valid,
    input  logic [7:0]                 scan_byte,
    input  logic                       pop,
    output logic [7:0]                 pop_data,
    output logic [$clog2(DEPTH+1)-1:0] q_count,
    output logic                       q_empty,
    output logic                       q_full,
    output logic                       busy
);
    logic       clear_q, rsp_push, led_skip;
    logic [7:0] rsp_data;
    logic       scan_take, code_valid;
    logic [7:0] code;
    logic       push;
    logic [7:0] push_data;

    kbd_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .busy      (busy),
        .clear_q   (clear_q),
        .rsp_push  (rsp_push),
        .rsp_data  (rsp_data),
        .led_skip  (led_skip)
    );

    assign scan_take = scan_valid && !busy && !clear_q;

    kbd_scan_xlate u_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_take  (scan_take),
        .scan_byte  (scan_byte),
        .code_valid (code_valid),
        .code       (code)
    );

    assign push      = rsp_push || code_valid;
    assign push_data = rsp_push ? rsp_data : code;

    kbd_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_q),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );
endmodule

// File: rtl/kbd_cmd_responder_chk.sv
module kbd_cmd_responder_chk #(
    parameter int DEPTH = 256
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic [7:0]                 cmd_byte,
    input logic                       scan_valid,
    input logic                       pop,
    input logic [7:0]                 pop_data,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       q_empty,
    input logic                       q_full,
    input logic                       busy,
    input logic                       led_skip
);
    logic accept;
    assign accept = cmd_valid && !busy && !led_skip;

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_byte == 8'h01 |=> q_empty && busy);

    a_r4_layout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (cmd_byte == 8'h07 || cmd_byte == 8'h0F) |=> q_empty && busy);

    a_r5_unknown_still: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_byte != 8'h01 && cmd_byte != 8'h07 && cmd_byte != 8'h0F
        && !scan_valid && !pop |=> $stable(q_count) && !busy);

    a_r3_led_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && led_skip && !scan_valid && !pop
        |=> !led_skip && !busy && $stable(q_count));

    a_r6_busy_one_push: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pop && !q_full |=> q_count == $past(q_count) + 1'b1);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= DEPTH);

    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && !pop && !cmd_valid |=> q_full);

    a_r11_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> pop_data == 8'h00);
endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .scan_valid (scan_valid),
    .pop        (pop),
    .pop_data   (pop_data),
    .q_count    (q_count),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .busy       (busy),
    .led_skip   (led_skip)
);

// File: tb/kbd_cmd_responder_tb.sv
module kbd_cmd_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, scan_valid, pop;
    logic [7:0] cmd_byte, scan_byte;
    logic [7:0] pop_data;
    logic [8:0] q_count;
    logic       q_empty, q_full, busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [7:0] mq[$];
    logic [1:0] m_caps = 0, m_num = 0;
    bit         m_ext = 0, m_led = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_cmd_responder #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .scan_valid(scan_valid), .scan_byte(scan_byte), .pop(pop),
        .pop_data(pop_data), .q_count(q_count), .q_empty(q_empty),
        .q_full(q_full), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] t_base(input logic [6:0] k);
        case (k)
            7'h01: return 8'h1D;
            7'h10: return 8'h36;
            7'h1C: return 8'h59;
            7'h3A: return 8'h77;
            7'h45: return 8'h62;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] t_ext(input logic [6:0] k);
        case (k)
            7'h1C: return 8'h5A;
            7'h35: return 8'h6D;
            7'h47: return 8'h44;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_push(input logic [7:0] b);
        if (mq.size() < DEPTH) mq.push_back(b);
    endfunction

    function automatic void m_scan(input logic [7:0] b);
        bit drop = 0;
        if (b == 8'h3A)      begin m_caps ^= 2'b01; drop = (m_caps == 2); end
        else if (b == 8'hBA) begin m_caps ^= 2'b10; drop = (m_caps == 3); end
        else if (b == 8'h45) begin m_num  ^= 2'b01; drop = (m_num == 2);  end
        else if (b == 8'hC5) begin m_num  ^= 2'b10; drop = (m_num == 3);  end
        if (b == 8'hE0) begin
            m_ext = 1;
        end else if (!drop) begin
            m_push((m_ext ? t_ext(b[6:0]) : t_base(b[6:0])) | (b & 8'h80));
            m_ext = 0;
        end
    endfunction

    function automatic void m_cmd(input logic [7:0] b);
        if (m_led) begin
            m_led = 0;
        end else begin
            case (b)
                8'h01: begin mq.delete(); m_push(8'hFF); m_push(8'h04); m_push(8'h7F); end
                8'h0E: m_led = 1;
                8'h07, 8'h0F: begin mq.delete(); m_push(8'hFE); m_push(8'h00); end
                default: ;
            endcase
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10 && busy; i++) tick();
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_valid = 1; cmd_byte = b;
        tick();
        cmd_valid = 0;
        m_cmd(b);
    endtask

    task automatic send_scan(input logic [7:0] b);
        scan_valid = 1; scan_byte = b;
        tick();
        scan_valid = 0;
        m_scan(b);
    endtask

    task automatic pop_check(input string req);
        logic [7:0] exp;
        exp = (mq.size() > 0) ? mq.pop_front() : 8'h00;
        chk(pop_data == exp, req, "pop_data", pop_data, exp);
        pop = 1;
        tick();
        pop = 0;
    endtask

    task automatic drain(input string req);
        int n = mq.size();
        chk(q_count == n, req, "count before drain", q_count, n);
        for (int i = 0; i < n; i++) pop_check(req);
        chk(q_empty, req, "empty after drain", q_empty, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] pool [13];
        void'($urandom(32'h1234_5A5A));
        pool = '{8'h01, 8'h1C, 8'h3A, 8'h45, 8'h10, 8'hE0, 8'hBA,
                 8'hC5, 8'h9C, 8'h47, 8'h35, 8'h81, 8'h90};
        rst_n = 0; cmd_valid = 0; scan_valid = 0; pop = 0;
        cmd_byte = 0; scan_byte = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk(q_count == 0, "R1", "q_count", q_count, 0);
        chk(q_empty == 1, "R1", "q_empty", q_empty, 1);
        chk(q_full == 0, "R1", "q_full", q_full, 0);
        chk(pop_data == 0, "R1", "pop_data", pop_data, 0);
        chk(busy == 0, "R1", "busy", busy, 0);

        // R11 pop on empty has no effect
        pop_check("R11");
        chk(q_count == 0, "R11", "count after empty pop", q_count, 0);

        // R2 identity reply after some queued codes
        send_scan(8'h01);
        send_scan(8'h10);
        send_cmd(8'h01);
        chk(busy == 1, "R2", "busy after accept", busy, 1);
        chk(q_count == 0, "R2", "cleared", q_count, 0);
        tick(); tick(); tick();
        chk(busy == 0, "R2", "busy after three", busy, 0);
        drain("R2");

        // R4 both layout queries
        send_scan(8'h1C);
        send_cmd(8'h07); wait_idle();
        drain("R4");
        send_cmd(8'h0F); wait_idle();
        drain("R4");

        // R5 unknown command leaves queue untouched
        send_scan(8'h10);
        send_cmd(8'h33);
        chk(busy == 0, "R5", "busy", busy, 0);
        drain("R5");

        // R3 LED data byte swallowed, even if it looks like a reset
        send_scan(8'h01);
        send_cmd(8'h0E);
        send_cmd(8'h01);
        chk(busy == 0, "R3", "busy after LED data", busy, 0);
        drain("R3");
        send_cmd(8'h07); wait_idle();
        drain("R3");

        // R6 collisions during a reply and with a clearing command
        send_scan(8'h10);
        send_cmd(8'h01);
        scan_valid = 1; scan_byte = 8'h01; tick(); scan_valid = 0;
        cmd_valid = 1; cmd_byte = 8'h07; tick(); cmd_valid = 0;
        wait_idle();
        drain("R6");
        scan_valid = 1; scan_byte = 8'h1C;
        cmd_valid = 1; cmd_byte = 8'h0F;
        tick();
        scan_valid = 0; cmd_valid = 0;
        m_cmd(8'h0F);
        wait_idle();
        drain("R6");

        // R7 base translation with release bit
        send_scan(8'h01); send_scan(8'h81); send_scan(8'h10); send_scan(8'h55);
        drain("R7");

        // R8 extended prefix
        send_scan(8'hE0); send_scan(8'h1C); send_scan(8'h1C);
        send_scan(8'hE0); send_scan(8'h9C); send_scan(8'hE0); send_scan(8'h47);
        drain("R8");

        // R9 lock filter: press, release, press, release on both keys
        send_scan(8'h3A); send_scan(8'hBA); send_scan(8'h3A); send_scan(8'hBA);
        send_scan(8'h45); send_scan(8'hC5); send_scan(8'h45); send_scan(8'hC5);
        chk(q_count == 4, "R9", "kept events", q_count, 4);
        drain("R9");

        // R10 fill to capacity, then overflow
        for (int i = 0; i < DEPTH; i++) send_scan(8'h10);
        chk(q_full == 1, "R10", "q_full", q_full, 1);
        chk(q_count == DEPTH, "R10", "q_count", q_count, DEPTH);
        send_scan(8'h01);
        chk(q_count == DEPTH, "R10", "count after overflow", q_count, DEPTH);
        pop_check("R10");
        chk(q_full == 0, "R10", "q_full after pop", q_full, 0);
        drain("R10");

        // R11 and R7/R8/R9 random traffic with pops against the model
        for (int i = 0; i < 600; i++) begin
            int r = $urandom % 8;
            if (r < 2 && mq.size() > 0) begin
                pop_check("R11");
            end else if (r == 2) begin
                send_scan(8'($urandom));
            end else begin
                send_scan(pool[$urandom % 13]);
            end
            chk(q_count == mq.size(), "R11", "random count", q_count, mq.size());
        end
        drain("R11");

        finish_run();
    end
endmodule